// File: doc/BRIEF.md
# Event Latency Timestamp Recorder

This block measures how long a fixed-latency processing chain takes, from the first input item sent to each result returned. It runs a free-running cycle counter on the processing clock. On the first read enable of the input memory it stores a start stamp. Each time a valid track returns, it stores the counter value together with the event index carried by that track. The records go into a capture memory that software-facing logic, or a later stage, reads back one address at a time.

Every read also produces a corrected latency. The read port subtracts the latest start stamp and the event index times the per-event cycle spacing from the stored stamp. This removes the offset that comes from interleaving events in time. With the default spacing of 36 cycles, every event's result lands in the same latency window. A clear input empties the capture memory between runs and leaves the counter running.

Top module: `lat_stamp_rec`

## Requirements
- R1: A TS_W-bit counter starts at 0 when reset is released. It adds one on every clock and wraps modulo 2^TS_W. Neither clear nor any strobe affects it.
- R2: A start record is created only on a rising edge of `start_i`, that is, `start_i` high in a cycle where it was low in the cycle before. Holding `start_i` high adds nothing more. The record has kind 0, event 0, and the counter value of the edge cycle.
- R3: In each cycle that `trk_vld_i` is high, a record is created with kind 1, event `trk_evt_i`, and the counter value of that cycle.
- R4: A start edge in a cycle with a valid track lets the track record be written in that cycle. The start record is deferred to the next cycle without a track and keeps the stamp of its edge cycle. A later start edge that arrives while one is deferred replaces it.
- R5: Records are written to consecutive addresses starting at 0, at most one per cycle. `records_o` gives the number stored.
- R6: When `records_o` equals DEPTH, any further record is dropped and `ovf_o` is set. `ovf_o` stays set until a clear.
- R7: `clr_i` sets `records_o` to 0, lowers `ovf_o`, and discards any deferred start. Strobes in the clear cycle create no record. The counter and the latest start stamp are unchanged.
- R8: The record at `rd_addr_i` appears on the read outputs after two clock edges.
- R9: `rd_lat_o` equals stamp − latest start stamp − event × CYC_PER_EVT, modulo 2^TS_W. The latest start stamp is the counter value of the most recent start edge.
- R10: After reset, `records_o` is 0 and `ovf_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Empty the capture memory and lower the overflow flag |
| start_i | input | 1 | Input memory read enable; its rising edge marks the start |
| trk_vld_i | input | 1 | A valid track has returned this cycle |
| trk_evt_i | input | EVT_W | Event index carried by the returned track |
| rd_addr_i | input | ADDR_W | Capture memory read address |
| rd_kind_o | output | 1 | Record kind: 0 start, 1 track |
| rd_evt_o | output | EVT_W | Stored event index |
| rd_ts_o | output | TS_W | Stored timestamp |
| rd_lat_o | output | TS_W | Corrected latency of the stored record |
| records_o | output | ADDR_W+1 | Number of records stored |
| ovf_o | output | 1 | Sticky flag: a record was dropped because the memory was full |

## Verification
A start edge and a valid track can arrive in the same cycle, and that case competes for the single write port. The bench provokes it with directed collisions. These include a collision followed directly by another track, and a second start edge while one is still deferred. Random phases with dense track traffic and frequent start toggling add more collisions. A reference model in the bench decides which record takes which address, and which stamp the deferred start carries. The full memory is read back after each phase, and the order and stamps are compared entry by entry.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  typedef enum logic {
    REC_START = 1'b0,
    REC_TRACK = 1'b1
  } rec_kind_e;
endpackage

// File: rtl/lsr_stamp_ctr.sv
module lsr_stamp_ctr #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst) cnt_o <= '0;
    else     cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/lsr_capture_ctl.sv
module lsr_capture_ctl
  import lsr_pkg::*;
#(
  parameter int TS_W   = 32,
  parameter int EVT_W  = 8,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 7,
  parameter int REC_W  = 1 + EVT_W + TS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              start_i,
  input  logic              trk_vld_i,
  input  logic [EVT_W-1:0]  trk_evt_i,
  input  logic [TS_W-1:0]   cnt_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [REC_W-1:0]  wr_data_o,
  output logic [CNT_W-1:0]  records_o,
  output logic              ovf_o,
  output logic [TS_W-1:0]   start_ref_o
);
  logic              start_q;
  logic              pend_vld;
  logic [TS_W-1:0]   pend_ts;
  logic              start_edge;
  logic              want;
  logic              full;
  rec_kind_e         kind;
  logic [EVT_W-1:0]  evt;
  logic [TS_W-1:0]   ts;

  assign start_edge = start_i & ~start_q;
  assign full       = (records_o == CNT_W'(DEPTH));

  // One write port: a track wins the slot, a start waits for a free cycle
  always_comb begin
    want = 1'b0;
    kind = REC_START;
    evt  = '0;
    ts   = cnt_i;
    if (!clr_i) begin
      if (trk_vld_i) begin
        want = 1'b1;
        kind = REC_TRACK;
        evt  = trk_evt_i;
      end else if (start_edge) begin
        want = 1'b1;
      end else if (pend_vld) begin
        want = 1'b1;
        ts   = pend_ts;
      end
    end
  end

  assign wr_en_o   = want & ~full;
  assign wr_addr_o = records_o[ADDR_W-1:0];
  assign wr_data_o = {kind, evt, ts};

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q     <= 1'b0;
      pend_vld    <= 1'b0;
      pend_ts     <= '0;
      records_o   <= '0;
      ovf_o       <= 1'b0;
      start_ref_o <= '0;
    end else begin
      start_q <= start_i;
      if (start_edge) start_ref_o <= cnt_i;
      if (clr_i) begin
        records_o <= '0;
        ovf_o     <= 1'b0;
        pend_vld  <= 1'b0;
      end else begin
        if (wr_en_o)      records_o <= records_o + 1'b1;
        if (want && full) ovf_o     <= 1'b1;
        if (trk_vld_i && start_edge) begin
          pend_vld <= 1'b1;
          pend_ts  <= cnt_i;
        end else if (!trk_vld_i) begin
          pend_vld <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/lsr_rec_ram.sv
module lsr_rec_ram #(
  parameter int W      = 41,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [W-1:0]      rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/lsr_lat_calc.sv
module lsr_lat_calc #(
  parameter int TS_W        = 32,
  parameter int EVT_W       = 8,
  parameter int CYC_PER_EVT = 36,
  parameter int REC_W       = 1 + EVT_W + TS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REC_W-1:0] rec_i,
  input  logic [TS_W-1:0]  start_ref_i,
  output logic             kind_o,
  output logic [EVT_W-1:0] evt_o,
  output logic [TS_W-1:0]  ts_o,
  output logic [TS_W-1:0]  lat_o
);
  logic             kind;
  logic [EVT_W-1:0] evt;
  logic [TS_W-1:0]  ts;
  logic [TS_W-1:0]  offset;

  assign {kind, evt, ts} = rec_i;
  assign offset = TS_W'(evt) * TS_W'(CYC_PER_EVT);

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_o <= 1'b0;
      evt_o  <= '0;
      ts_o   <= '0;
      lat_o  <= '0;
    end else begin
      kind_o <= kind;
      evt_o  <= evt;
      ts_o   <= ts;
      lat_o  <= ts - start_ref_i - offset;
    end
  end
endmodule

// File: rtl/lat_stamp_rec.sv
module lat_stamp_rec #(
  parameter int TS_W        = 32,
  parameter int EVT_W       = 8,
  parameter int DEPTH       = 64,
  parameter int CYC_PER_EVT = 36,
  localparam int ADDR_W     = $clog2(DEPTH),
  localparam int CNT_W      = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              start_i,
  input  logic              trk_vld_i,
  input  logic [EVT_W-1:0]  trk_evt_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_kind_o,
  output logic [EVT_W-1:0]  rd_evt_o,
  output logic [TS_W-1:0]   rd_ts_o,
  output logic [TS_W-1:0]   rd_lat_o,
  output logic [CNT_W-1:0]  records_o,
  output logic              ovf_o
);
  localparam int REC_W = 1 + EVT_W + TS_W;

  logic [TS_W-1:0]   cnt;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [REC_W-1:0]  wr_data;
  logic [REC_W-1:0]  rd_data;
  logic [TS_W-1:0]   start_ref;

  lsr_stamp_ctr #(.TS_W(TS_W)) u_ctr (
    .clk(clk), .rst(rst), .cnt_o(cnt)
  );

  lsr_capture_ctl #(
    .TS_W(TS_W), .EVT_W(EVT_W), .DEPTH(DEPTH),
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .REC_W(REC_W)
  ) u_ctl (
    .clk(clk), .rst(rst), .clr_i(clr_i), .start_i(start_i),
    .trk_vld_i(trk_vld_i), .trk_evt_i(trk_evt_i), .cnt_i(cnt),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .records_o(records_o), .ovf_o(ovf_o), .start_ref_o(start_ref)
  );

  lsr_rec_ram #(.W(REC_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we_i(wr_en), .waddr_i(wr_addr), .wdata_i(wr_data),
    .raddr_i(rd_addr_i), .rdata_o(rd_data)
  );

  lsr_lat_calc #(
    .TS_W(TS_W), .EVT_W(EVT_W), .CYC_PER_EVT(CYC_PER_EVT), .REC_W(REC_W)
  ) u_lat (
    .clk(clk), .rst(rst), .rec_i(rd_data), .start_ref_i(start_ref),
    .kind_o(rd_kind_o), .evt_o(rd_evt_o), .ts_o(rd_ts_o), .lat_o(rd_lat_o)
  );
endmodule

// File: rtl/lsr_checker.sv
module lsr_checker #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             clr_i,
  input logic             trk_vld_i,
  input logic [CNT_W-1:0] records_i,
  input logic             ovf_i
);
  AST_TRK_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    (trk_vld_i && !clr_i && records_i < CNT_W'(DEPTH)) |=> records_i == $past(records_i) + 1'b1); // R3
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    records_i <= CNT_W'(DEPTH)); // R5
  AST_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (records_i == $past(records_i)) || (records_i == $past(records_i) + 1'b1)); // R5
  AST_FULL_SETS_OVF: assert property (@(posedge clk) disable iff (rst)
    (trk_vld_i && !clr_i && records_i == CNT_W'(DEPTH)) |=> ovf_i); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_i && !clr_i) |=> ovf_i); // R6
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (records_i == '0) && !ovf_i); // R7
endmodule

bind lat_stamp_rec lsr_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .clr_i(clr_i), .trk_vld_i(trk_vld_i),
  .records_i(records_o), .ovf_i(ovf_o)
);

// File: tb/test_lat_stamp_rec.sv
module test_lat_stamp_rec;
  localparam int TS_W = 32, EVT_W = 8, DEPTH = 64, AW = 6, CW = 7, CYC = 36;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, clr_i = 1'b0, start_i = 1'b0, trk_vld_i = 1'b0;
  logic [EVT_W-1:0] trk_evt_i = '0;
  logic [AW-1:0]    rd_addr_i = '0;
  logic             rd_kind_o, ovf_o;
  logic [EVT_W-1:0] rd_evt_o;
  logic [TS_W-1:0]  rd_ts_o, rd_lat_o;
  logic [CW-1:0]    records_o;

  lat_stamp_rec i_lat_stamp_rec (
    .clk(clk), .rst(rst), .clr_i(clr_i), .start_i(start_i),
    .trk_vld_i(trk_vld_i), .trk_evt_i(trk_evt_i), .rd_addr_i(rd_addr_i),
    .rd_kind_o(rd_kind_o), .rd_evt_o(rd_evt_o), .rd_ts_o(rd_ts_o),
    .rd_lat_o(rd_lat_o), .records_o(records_o), .ovf_o(ovf_o)
  );

  // Cycle count since reset release: the value the stamp counter holds (R1)
  logic [31:0] cyc;
  always @(posedge clk) if (rst) cyc <= '0; else cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic        m_kind [DEPTH];
  logic [7:0]  m_evt  [DEPTH];
  logic [31:0] m_ts   [DEPTH];
  int          m_cnt = 0;
  bit          m_ovf = 0, m_pend = 0, m_sq = 0;
  logic [31:0] m_pts = '0, m_sref = '0, last_cyc = '0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_lat(logic [31:0] ts, logic [7:0] e, logic [31:0] sref);
    return ts - sref - {24'b0, e} * 32'd36;
  endfunction

  function automatic void mput(logic k, logic [7:0] e, logic [31:0] t);
    if (m_cnt == DEPTH) m_ovf = 1;
    else begin
      m_kind[m_cnt] = k; m_evt[m_cnt] = e; m_ts[m_cnt] = t; m_cnt++;
    end
  endfunction

  task automatic step(bit s, bit t, logic [7:0] e, bit c);
    bit sedge;
    @(negedge clk);
    start_i = s; trk_vld_i = t; trk_evt_i = e; clr_i = c;
    last_cyc = cyc;
    sedge = s & ~m_sq; m_sq = s;
    if (sedge) m_sref = cyc;
    if (c) begin
      m_cnt = 0; m_ovf = 0; m_pend = 0;
    end else if (t) begin
      mput(1'b1, e, cyc);
      if (sedge) begin m_pend = 1; m_pts = cyc; end
    end else if (sedge) begin
      mput(1'b0, 8'd0, cyc); m_pend = 0;
    end else if (m_pend) begin
      mput(1'b0, 8'd0, m_pts); m_pend = 0;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'd0, 0);
  endtask

  // R8: address driven at a negedge, record valid after two rising edges
  task automatic rd(int a);
    @(negedge clk);
    rd_addr_i = AW'(a);
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic readback();
    idle(3);
    chk("R5 count", 32'(records_o), 32'(m_cnt));
    chk("R6 overflow", 32'(ovf_o), 32'(m_ovf));
    for (int i = 0; i < m_cnt; i++) begin
      rd(i);
      chk(m_kind[i] ? "R3 R8 kind" : "R2 R8 kind", 32'(rd_kind_o), 32'(m_kind[i]));
      chk(m_kind[i] ? "R3 event" : "R2 event", 32'(rd_evt_o), 32'(m_evt[i]));
      chk(m_kind[i] ? "R3 stamp" : "R2 stamp", rd_ts_o, m_ts[i]);
      chk("R9 latency", rd_lat_o, exp_lat(m_ts[i], m_evt[i], m_sref));
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] cc, t0;
    void'($urandom(32'd20170828));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 count", 32'(records_o), 32'd0);
    chk("R10 overflow", 32'(ovf_o), 32'd0);
    rst = 1'b0;

    // R2: start held high gives one record only
    idle(2);
    for (int i = 0; i < 5; i++) step(1, 0, 8'd0, 0);
    step(0, 1, 8'd3, 0);
    step(0, 1, 8'd200, 0);
    readback();
    chk("R2 single start", 32'(records_o), 32'd3);

    // R4: collision, start deferred behind two tracks
    step(0, 0, 8'd0, 1);
    step(1, 1, 8'd5, 0); cc = last_cyc;
    step(1, 1, 8'd6, 0);
    step(0, 0, 8'd0, 0);
    readback();
    rd(0); chk("R4 track first", 32'(rd_kind_o), 32'd1);
    rd(2); chk("R4 deferred kind", 32'(rd_kind_o), 32'd0);
    chk("R4 deferred stamp", rd_ts_o, cc);
    // R4: second edge while deferred replaces the stamp
    step(0, 0, 8'd0, 1);
    step(1, 1, 8'd1, 0);
    step(0, 1, 8'd2, 0);
    step(1, 1, 8'd3, 0); cc = last_cyc;
    step(0, 0, 8'd0, 0);
    readback();
    rd(3); chk("R4 replaced stamp", rd_ts_o, cc);

    // R7: strobes in clear cycle ignored; deferred start discarded
    step(0, 0, 8'd0, 1);
    step(1, 1, 8'd9, 0);
    step(0, 1, 8'd4, 1);
    idle(2);
    chk("R7 clear empties", 32'(records_o), 32'd0);
    step(0, 1, 8'd7, 0); t0 = last_cyc;
    readback();
    rd(0); chk("R1 counter runs through clear", rd_ts_o, t0);
    chk("R7 clear kept start ref", rd_lat_o, exp_lat(t0, 8'd7, m_sref));

    // R6: fill past DEPTH
    step(0, 0, 8'd0, 1);
    for (int i = 0; i < DEPTH + 6; i++) step(i == 10, 1, 8'(i), 0);
    idle(4);
    chk("R6 full count", 32'(records_o), 32'(DEPTH));
    chk("R6 sticky", 32'(ovf_o), 32'd1);
    readback();
    step(0, 0, 8'd0, 1);
    idle(1);
    chk("R7 clear overflow", 32'(ovf_o), 32'd0);

    // Random phases with varying density
    for (int r = 0; r < 6; r++) begin
      int ps = 10 + r * 12, pt = 20 + r * 14;
      for (int i = 0; i < 150; i++)
        step(($urandom % 100) < ps, ($urandom % 100) < pt, 8'($urandom),
             ($urandom % 100) < 1);
      readback();
      step(0, 0, 8'd0, 1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule